// File: doc/BRIEF.md
# UART frame receiver

This block recovers characters from an asynchronous serial line. The line is sampled on a 16x oversampling tick that a separate baud generator supplies. A falling edge on the line starts a frame. The receiver confirms the start bit half a bit later. It then samples every data bit, the optional parity bit and one stop bit at its centre.

The frame shape is set by a small set of configuration inputs:
- a 2-bit word-length code;
- a parity enable;
- an even/odd select;
- a stick-parity select.

These inputs carry the same meanings the matching transmitter uses. The receiver captures them when it accepts a start bit, so a change in the middle of a frame has no effect on the frame in progress.

Each finished character goes into a single holding register, together with three flags: parity error, framing error and break. The register stays valid until the consumer acknowledges it. If a second character finishes before that acknowledgement, an overrun flag is raised and the older character is kept.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_overrun`, `rx_par_err`, `rx_frame_err` and `rx_break` are all 0.
- R2: The `cfg_wlen` code selects the number of data bits:

  | `cfg_wlen` | Data bits |
  |---|---|
  | 00 | 5 |
  | 01 | 6 |
  | 10 | 7 |
  | 11 | 8 |

  Data arrives LSB first and appears in the low bits of `rx_data`. Unused upper bits read 0.
- R3: A low level that is gone by the middle of the start bit (8 ticks after the falling edge) is discarded. The receiver returns to idle and produces no character.
- R4: With `cfg_par_en`=0, no parity bit is expected. The bit after the last data bit is taken as the stop bit, and `rx_par_err` is 0.
- R5: With `cfg_par_en`=1 and `cfg_stick`=0, the count of 1s over the data and parity bits must be even when `cfg_even_sel`=1 and odd when it is 0. Otherwise `rx_par_err` is 1.
- R6: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit must be 1 when `cfg_even_sel`=0 and 0 when `cfg_even_sel`=1. Otherwise `rx_par_err` is 1.
- R7: A stop bit sampled as 0 sets `rx_frame_err`.
- R8: A character whose data bits, parity bit (when enabled) and stop bit are all 0 sets `rx_break`, together with `rx_frame_err`.
- R9: Only one stop bit is sampled. A start bit may follow the first stop bit directly, and both characters are received intact.
- R10: A character stays in the holding register, with `rx_valid`=1 and its fields unchanged, until `rd_ack` is high for one clock. That clock clears `rx_valid` and `rx_overrun`.
- R11: If a character finishes while `rx_valid`=1 and no `rd_ack` is given, `rx_overrun` becomes 1 and the held character is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line; idles high |
| cfg_wlen | input | 2 | Word-length code: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_par_en | input | 1 | Expect a parity bit |
| cfg_even_sel | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stick | input | 1 | Fixed parity bit value, inverse of `cfg_even_sel` |
| rd_ack | input | 1 | Consumer has taken the held character |
| rx_valid | output | 1 | Holding register is full |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch on the held character |
| rx_frame_err | output | 1 | Stop bit of the held character was 0 |
| rx_break | output | 1 | Held character was an all-zero break frame |
| rx_overrun | output | 1 | A character was lost while the register was full |

## Verification
The hardest situation to bring about is the one-stop-bit rule. A frame whose "second stop bit" is already the next start bit shows it: the receiver must re-arm on that bit without having seen a second high bit. The bench shows this by sending two frames back to back, with the second falling edge half a bit after the first stop sample. Overrun is reached in a similar way: the consumer that acknowledges characters is switched off, two frames are sent, and only then is the held character inspected. Start-bit rejection uses a low pulse three ticks long, which ends well before the mid-bit check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
  } rx_cfg_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_err;
    logic              frame_err;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign d_out = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_s,
  input  rx_cfg_t  cfg,
  output logic     done,
  output rx_char_t char_out
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              par_q, par_d;
  logic              prev_q, prev_d;
  rx_cfg_t           cfg_q, cfg_d;
  logic              done_q, done_d;
  rx_char_t          char_q, char_d;
  logic [3:0]        nbits;
  logic              centre;
  logic              ones;

  assign nbits  = {2'b00, cfg_q.wlen} + 4'd5;
  assign centre = tick && (cnt_q == CW'(OVS - 1));
  assign ones   = (^data_q) ^ par_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    prev_d  = tick ? rx_s : prev_q;
    done_d  = 1'b0;
    char_d  = char_q;
    case (state_q)
      ST_IDLE: begin
        if (tick && prev_q && !rx_s) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == CW'(HALF - 1)) begin
            if (!rx_s) begin
              state_d = ST_DATA;
              cnt_d   = '0;
              idx_d   = '0;
              data_d  = '0;
              par_d   = 1'b0;
              cfg_d   = cfg;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (centre) begin
          cnt_d         = '0;
          data_d[idx_q] = rx_s;
          if ({1'b0, idx_q} == nbits - 4'd1)
            state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          else
            idx_d = idx_q + 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (centre) begin
          cnt_d   = '0;
          par_d   = rx_s;
          state_d = ST_STOP;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (centre) begin
          state_d          = ST_IDLE;
          cnt_d            = '0;
          done_d           = 1'b1;
          char_d.data      = data_q;
          char_d.frame_err = !rx_s;
          char_d.par_err   = cfg_q.par_en &&
                             (cfg_q.stick ? (par_q == cfg_q.even) : (ones ^ !cfg_q.even));
          char_d.brk       = (data_q == '0) && (!cfg_q.par_en || !par_q) && !rx_s;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      par_q   <= par_d;
      prev_q  <= prev_d;
      cfg_q   <= cfg_d;
      done_q  <= done_d;
      char_q  <= char_d;
    end
  end

  assign done     = done_q;
  assign char_out = char_q;

  assert_nopar_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg_q.par_en) |-> !char_q.par_err);
  assert_break_ferr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && char_q.brk) |-> char_q.frame_err);
  assert_glitch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == CW'(HALF - 1) && rx_s) |=> (state_q == ST_IDLE));
  assert_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> ({1'b0, idx_q} < nbits));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rx_char_t char_in,
  input  logic     rd_ack,
  output logic     valid,
  output logic     overrun,
  output rx_char_t char_out
);
  logic     valid_q, valid_d;
  logic     ovr_q, ovr_d;
  rx_char_t char_q, char_d;

  always_comb begin
    valid_d = valid_q;
    ovr_d   = ovr_q;
    char_d  = char_q;
    if (rd_ack && valid_q) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
    if (load) begin
      if (valid_d) begin
        ovr_d = 1'b1;
      end else begin
        char_d  = char_in;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
      char_q  <= char_d;
    end
  end

  assign valid    = valid_q;
  assign overrun  = ovr_q;
  assign char_out = char_q;

  assert_keep_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_ack && load) |=> (ovr_q && $stable(char_q)));
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rd_ack && !load) |=> (!valid_q && !ovr_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_ack) |=> (valid_q && $stable(char_q)));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_even_sel,
  input  logic              cfg_stick,
  input  logic              rd_ack,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frame_err,
  output logic              rx_break,
  output logic              rx_overrun
);
  logic     rx_s;
  logic     frame_done;
  rx_cfg_t  cfg;
  rx_char_t frame_char, held_char;

  assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, even: cfg_even_sel, stick: cfg_stick};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .cfg(cfg),
    .done(frame_done), .char_out(frame_char)
  );

  uart_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .char_in(frame_char),
    .rd_ack(rd_ack), .valid(rx_valid), .overrun(rx_overrun), .char_out(held_char)
  );

  assign rx_data      = held_char.data;
  assign rx_par_err   = held_char.par_err;
  assign rx_frame_err = held_char.frame_err;
  assign rx_break     = held_char.brk;
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_par_en = 1'b0, cfg_even_sel = 1'b0, cfg_stick = 1'b0;
  logic       rd_ack = 1'b0;
  logic       rx_valid, rx_par_err, rx_frame_err, rx_break, rx_overrun;
  logic [7:0] rx_data;

  int  n_checks = 0, n_fail = 0;
  bit  mon_en = 1'b1;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic pe, fe, bk;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_even_sel(cfg_even_sel),
    .cfg_stick(cfg_stick), .rd_ack(rd_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break),
    .rx_overrun(rx_overrun)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic bit_out(input logic v);
    rx_in = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                      input logic ev, input logic st, input logic force_p,
                      input logic fp, input logic stop_v, input int idle_bits,
                      input logic push, input string tag);
    logic [7:0] mask, m;
    logic good_p, sent_p;
    exp_t e;
    mask   = 8'hFF >> (3 - wl);
    m      = d & mask;
    good_p = st ? ~ev : (ev ? ^m : ~^m);
    sent_p = force_p ? fp : good_p;
    e.d   = m;
    e.pe  = pe && (sent_p != good_p);
    e.fe  = !stop_v;
    e.bk  = (m == 8'h00) && (!pe || !sent_p) && !stop_v;
    e.tag = tag;
    if (push) exp_q.push_back(e);
    cfg_wlen = wl; cfg_par_en = pe; cfg_even_sel = ev; cfg_stick = st;
    bit_out(1'b0);
    for (int i = 0; i < 5 + int'(wl); i++) bit_out(m[i]);
    if (pe) bit_out(sent_p);
    bit_out(stop_v);
    rx_in = 1'b1;
    repeat (idle_bits * 64) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rx_valid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL unexpected character (R3): actual %h expected none", rx_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " data"}, {8'h00, rx_data}, {8'h00, e.d});
          check({e.tag, " flags"}, {12'h000, rx_par_err, rx_frame_err, rx_break, rx_overrun},
                {12'h000, e.pe, e.fe, e.bk, 1'b0});
        end
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset flags", {11'h0, rx_valid, rx_overrun, rx_par_err, rx_frame_err, rx_break}, 16'h0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 after release", {14'h0, rx_valid, rx_overrun}, 16'h0);

    // R2 word lengths, R4 no parity
    send(8'hA5, 2'b11, 0, 0, 0, 0, 0, 1, 2, 1, "R2 R4 8bit");
    send(8'hF3, 2'b00, 0, 0, 0, 0, 0, 1, 2, 1, "R2 5bit");
    send(8'hEA, 2'b01, 0, 0, 0, 0, 0, 1, 2, 1, "R2 6bit");
    send(8'hD5, 2'b10, 0, 0, 0, 0, 0, 1, 2, 1, "R2 7bit");
    // R5 normal parity
    send(8'h31, 2'b11, 1, 1, 0, 0, 0, 1, 2, 1, "R5 even good");
    send(8'h31, 2'b11, 1, 1, 0, 1, 0, 1, 2, 1, "R5 even bad");
    send(8'h07, 2'b10, 1, 0, 0, 0, 0, 1, 2, 1, "R5 odd good");
    send(8'h07, 2'b10, 1, 0, 0, 1, 0, 1, 2, 1, "R5 odd bad");
    // R6 stick parity
    send(8'h5C, 2'b11, 1, 0, 1, 0, 0, 1, 2, 1, "R6 stick one good");
    send(8'h5C, 2'b11, 1, 0, 1, 1, 0, 1, 2, 1, "R6 stick one bad");
    send(8'h18, 2'b01, 1, 1, 1, 0, 0, 1, 2, 1, "R6 stick zero good");
    send(8'h18, 2'b01, 1, 1, 1, 1, 1, 1, 2, 1, "R6 stick zero bad");
    // R7 framing error, R8 break
    send(8'h7E, 2'b11, 0, 0, 0, 0, 0, 0, 2, 1, "R7 stop low");
    send(8'h00, 2'b11, 1, 1, 0, 1, 0, 0, 2, 1, "R8 break");
    send(8'h00, 2'b11, 1, 1, 0, 1, 1, 0, 2, 1, "R8 parity high no break");

    // R3 short low pulse
    rx_in = 1'b0;
    repeat (12) @(negedge clk);
    rx_in = 1'b1;
    repeat (800) @(negedge clk);
    check("R3 glitch ignored", {15'h0, rx_valid}, 16'h0);

    // R9 back-to-back frames, one stop bit each
    send(8'h96, 2'b11, 1, 0, 0, 0, 0, 1, 0, 1, "R9 first");
    send(8'h69, 2'b11, 1, 0, 0, 0, 0, 1, 2, 1, "R9 second");

    // R10 / R11 hold and overrun
    mon_en = 1'b0;
    send(8'h4B, 2'b11, 0, 0, 0, 0, 0, 1, 1, 0, "R11 first");
    check("R10 held valid", {15'h0, rx_valid}, 16'h1);
    send(8'hB4, 2'b11, 0, 0, 0, 0, 0, 1, 1, 0, "R11 second");
    check("R11 old data kept", {8'h0, rx_data}, 16'h004B);
    check("R11 overrun set", {14'h0, rx_valid, rx_overrun}, 16'h3);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
    check("R10 ack clears", {14'h0, rx_valid, rx_overrun}, 16'h0);
    mon_en = 1'b1;
    send(8'h3C, 2'b11, 0, 0, 0, 0, 0, 1, 2, 1, "R10 after ack");

    check("scoreboard drained", 16'(exp_q.size()), 16'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule